// File: doc/BRIEF.md
# Trace Buffer Write Engine

This block is a memory-backed sink for a byte-wide trace stream. Software programs a buffer region with a page-aligned lower bound (base), a page-aligned exclusive upper bound (limit) and a byte write pointer that lies inside the region. Once capture is enabled, each accepted trace byte is issued to a memory port as a single write request at the current pointer. The pointer then moves up by one. When a byte is written to the last address below the limit, the pointer returns to base, which is a wrap event.

Two wrap behaviours are selectable. In stop-on-wrap mode, capture halts on the wrap. The block clears its own enable bit, records a sticky wrap/stop/interrupt status with a "buffer filled" code, and leaves the pointer equal to base. Software can then tell a genuine full-buffer stop from a stray interrupt. In continuous mode, the wrap only raises wrap and interrupt status, and capture carries on. An optional trigger input can also halt capture. A drain handshake lets software wait until every accepted byte has left the memory port.

Top module: `trace_buf_writer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `tr_ready`, `mem_req`, `irq` and `drain_ack` are low.
- R2: Register map: address 0 is base, address 1 is the write pointer, address 2 is control, address 3 is status. Base and the limit field hold only bits above the page size (bits 11:0 read zero with default parameters). The write pointer holds all bits.
- R3: An accepted byte appears on the next cycle as `mem_req`, with `mem_addr` equal to the pointer and `mem_data` equal to the byte. The pointer advances by one. The request, address and data are held until `mem_gnt`.
- R4: `tr_ready` is high only when the control enable bit (bit 0) is set, the status stop flag is clear, no drain is pending, and the memory port is free (`mem_req` low or `mem_gnt` high).
- R5: With the fill field (control bits 2:1) at 00, accepting a byte at limit-1 sets the pointer to base and sets these status bits: irq (bit 0), wrap (bit 2), stop (bit 3), and buffer code 01 in bits 9:8. The event class in bits 7:4 is 0. Capture stops on the next cycle.
- R6: With the fill field at 01, a wrap sets the pointer to base and sets the wrap and irq status bits only. Capture continues.
- R7: With the trigger field (control bits 4:3) at 01, a high `tr_trig` while capturing sets status trig (bit 1), stop and irq, and halts capture. With the trigger field at 00, `tr_trig` has no effect.
- R8: A halt clears only the control enable bit. The limit, fill and trigger fields read back unchanged.
- R9: `irq` is a level that equals the status irq bit and stays high until software clears it.
- R10: A write to status replaces its contents. A hardware event in the same cycle still sets its flags on top of the written value.
- R11: A one-cycle `drain_req` holds `tr_ready` low. It returns a single-cycle `drain_ack` once no write request is outstanding.
- R12: While the status stop flag is set, setting the enable bit does not restart capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational on reg_addr) |
| tr_valid | input | 1 | Trace byte valid |
| tr_data | input | 8 | Trace byte |
| tr_ready | output | 1 | Trace byte accepted when high with tr_valid |
| tr_trig | input | 1 | Trigger condition |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_data | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory port takes the request |
| drain_req | input | 1 | Drain request pulse |
| drain_ack | output | 1 | Drain complete pulse |
| irq | output | 1 | Maintenance interrupt level |

## Verification
A software write to the status register can land in the same cycle as the byte that wraps the buffer in stop-on-wrap mode. The bench provokes this by driving a status clear together with the final byte at limit-1. A correct design must keep the sticky stop, wrap, irq and filled code rather than lose them to the clear. A drain request issued in the same cycle as a byte acceptance is also exercised. There, the acknowledge must wait until that byte's write request has been granted.

// File: rtl/tbw_pkg.sv
// Shared register addresses, field codes and status/event types
// for the trace buffer write engine.
package tbw_pkg;

    localparam logic [1:0] RA_BASE = 2'd0;
    localparam logic [1:0] RA_WPTR = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam logic [1:0] FILL_STOP = 2'b00;
    localparam logic [1:0] FILL_WRAP = 2'b01;

    localparam logic [1:0] TRIG_IGNORE = 2'b00;
    localparam logic [1:0] TRIG_HALT   = 2'b01;

    localparam logic [1:0] BSC_FILLED = 2'b01;
    localparam logic [3:0] EC_OTHER   = 4'd0;

    localparam int STAT_W = 10;

    // Status register layout, MSB first: code[9:8], class[7:4], stop, wrap, trig, irq
    typedef struct packed {
        logic [1:0] bsc;
        logic [3:0] ec;
        logic       stop;
        logic       wrap;
        logic       trig;
        logic       irq;
    } stat_t;

    // Hardware events raised by the capture path in one cycle
    typedef struct packed {
        logic irq;
        logic wrap;
        logic trig;
        logic halt;
        logic filled;
    } evt_t;

endpackage

// File: rtl/tbw_cfg.sv
// Register file of the trace buffer write engine: base, control
// (enable, fill mode, trigger mode, limit) and sticky status.
// Assumes ADDR_W > PAGE_LG >= 5 and ADDR_W >= STAT_W. Hardware events win
// over a software write to the same register in the same cycle.
module tbw_cfg
    import tbw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PAGE_LG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  evt_t              evt,
    input  logic [ADDR_W-1:0] wptr,
    output logic              sw_wptr_we,
    output logic [ADDR_W-1:0] sw_wptr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] limit_addr,
    output logic              enable,
    output logic [1:0]        fill_mode,
    output logic [1:0]        trig_mode,
    output stat_t             stat
);

    localparam int PG_W = ADDR_W - PAGE_LG;

    logic [PG_W-1:0] base_pg;
    logic [PG_W-1:0] limit_pg;
    logic            en_q;
    logic [1:0]      fill_q;
    logic [1:0]      trig_q;
    stat_t           stat_q;
    stat_t           stat_d;

    logic wr_base, wr_ctrl, wr_stat;

    // Decode software write strobes
    always_comb begin
        wr_base    = reg_wr && (reg_addr == RA_BASE);
        sw_wptr_we = reg_wr && (reg_addr == RA_WPTR);
        wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
        wr_stat    = reg_wr && (reg_addr == RA_STAT);
        sw_wptr    = reg_wdata;
    end

    // Base and control registers; a halt event drops only the enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pg  <= '0;
            limit_pg <= '0;
            en_q     <= 1'b0;
            fill_q   <= FILL_STOP;
            trig_q   <= TRIG_IGNORE;
        end else begin
            if (wr_base)
                base_pg <= reg_wdata[ADDR_W-1:PAGE_LG];
            if (wr_ctrl) begin
                limit_pg <= reg_wdata[ADDR_W-1:PAGE_LG];
                en_q     <= reg_wdata[0];
                fill_q   <= reg_wdata[2:1];
                trig_q   <= reg_wdata[4:3];
            end
            if (evt.halt)
                en_q <= 1'b0;
        end
    end

    // Next status: software value first, then hardware flags on top
    always_comb begin
        stat_d = wr_stat ? stat_t'(reg_wdata[STAT_W-1:0]) : stat_q;
        if (evt.irq)  stat_d.irq  = 1'b1;
        if (evt.wrap) stat_d.wrap = 1'b1;
        if (evt.trig) stat_d.trig = 1'b1;
        if (evt.halt) stat_d.stop = 1'b1;
        if (evt.filled) begin
            stat_d.bsc = BSC_FILLED;
            stat_d.ec  = EC_OTHER;
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Register read multiplexer
    always_comb begin
        unique case (reg_addr)
            RA_BASE: reg_rdata = {base_pg, {PAGE_LG{1'b0}}};
            RA_WPTR: reg_rdata = wptr;
            RA_CTRL: reg_rdata = {limit_pg, {(PAGE_LG-5){1'b0}}, trig_q, fill_q, en_q};
            default: reg_rdata = {{(ADDR_W-STAT_W){1'b0}}, stat_q};
        endcase
    end

    assign base_addr  = {base_pg, {PAGE_LG{1'b0}}};
    assign limit_addr = {limit_pg, {PAGE_LG{1'b0}}};
    assign enable     = en_q;
    assign fill_mode  = fill_q;
    assign trig_mode  = trig_q;
    assign stat       = stat_q;

endmodule

// File: rtl/tbw_capture.sv
// Capture path: accepts trace bytes, issues one memory write per byte,
// advances the write pointer and detects wrap and trigger events.
// Assumes software keeps base <= wptr < limit while enabled.
module tbw_capture
    import tbw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] limit_addr,
    input  logic              enable,
    input  logic              halted,
    input  logic              hold,
    input  logic [1:0]        fill_mode,
    input  logic [1:0]        trig_mode,
    input  logic              sw_wptr_we,
    input  logic [ADDR_W-1:0] sw_wptr,
    input  logic              tr_valid,
    input  logic [7:0]        tr_data,
    input  logic              tr_trig,
    output logic              tr_ready,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic [ADDR_W-1:0] wptr,
    output evt_t              evt
);

    logic run, port_free, accept, at_end, wrap_hit, fill_halt, trig_hit;

    // Acceptance and event detection
    always_comb begin
        run       = enable && !halted && !hold;
        port_free = !mem_req || mem_gnt;
        tr_ready  = run && port_free;
        accept    = tr_valid && tr_ready;
        at_end    = (wptr + ADDR_W'(1)) == limit_addr;
        wrap_hit  = accept && at_end;
        fill_halt = wrap_hit && (fill_mode != FILL_WRAP);
        trig_hit  = run && tr_trig && (trig_mode == TRIG_HALT);
        evt.irq    = wrap_hit || trig_hit;
        evt.wrap   = wrap_hit;
        evt.trig   = trig_hit;
        evt.halt   = fill_halt || trig_hit;
        evt.filled = fill_halt;
    end

    // Write pointer: hardware advance has priority over a software load
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (accept)
            wptr <= at_end ? base_addr : wptr + ADDR_W'(1);
        else if (sw_wptr_we)
            wptr <= sw_wptr;
    end

    // Memory write request, held until granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else if (accept) begin
            mem_req  <= 1'b1;
            mem_addr <= wptr;
            mem_data <= tr_data;
        end else if (mem_gnt) begin
            mem_req  <= 1'b0;
        end
    end

endmodule

// File: rtl/tbw_drain.sv
// Drain handshake: remembers a request, holds capture off, and pulses
// an acknowledge once no write request is outstanding.
module tbw_drain (
    input  logic clk,
    input  logic rst_n,
    input  logic drain_req,
    input  logic busy,
    output logic pend,
    output logic ack
);

    // Pending flag and single-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            ack  <= 1'b0;
        end else if (pend && !busy && !ack) begin
            ack  <= 1'b1;
            pend <= drain_req;
        end else begin
            ack  <= 1'b0;
            pend <= pend || drain_req;
        end
    end

endmodule

// File: rtl/trace_buf_writer.sv
// Top level of the trace buffer write engine: joins register file,
// capture path and drain handshake. irq is the status irq level.
module trace_buf_writer
    import tbw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PAGE_LG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              tr_valid,
    input  logic [7:0]        tr_data,
    output logic              tr_ready,
    input  logic              tr_trig,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    input  logic              mem_gnt,
    input  logic              drain_req,
    output logic              drain_ack,
    output logic              irq
);

    evt_t              ev;
    stat_t             stat;
    logic [ADDR_W-1:0] cfg_base, cfg_limit, wptr, sw_wptr;
    logic              sw_wptr_we, enable, drain_pend;
    logic [1:0]        fill_mode, trig_mode;
    logic              ev_wrap, ev_halt;

    tbw_cfg #(.ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt(ev), .wptr(wptr),
        .sw_wptr_we(sw_wptr_we), .sw_wptr(sw_wptr),
        .base_addr(cfg_base), .limit_addr(cfg_limit), .enable(enable),
        .fill_mode(fill_mode), .trig_mode(trig_mode), .stat(stat)
    );

    tbw_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .base_addr(cfg_base), .limit_addr(cfg_limit), .enable(enable),
        .halted(stat.stop), .hold(drain_pend),
        .fill_mode(fill_mode), .trig_mode(trig_mode),
        .sw_wptr_we(sw_wptr_we), .sw_wptr(sw_wptr),
        .tr_valid(tr_valid), .tr_data(tr_data), .tr_trig(tr_trig),
        .tr_ready(tr_ready), .mem_gnt(mem_gnt), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .wptr(wptr), .evt(ev)
    );

    tbw_drain u_drain (
        .clk(clk), .rst_n(rst_n), .drain_req(drain_req),
        .busy(mem_req), .pend(drain_pend), .ack(drain_ack)
    );

    assign irq     = stat.irq;
    assign ev_wrap = ev.wrap;
    assign ev_halt = ev.halt;

endmodule

// File: rtl/trace_buf_writer_chk.sv
// Property checker for the trace buffer write engine, bound to the top.
module trace_buf_writer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tr_ready,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_data,
    input logic              irq,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic              drain_ack,
    input logic              drain_pend,
    input logic              ev_wrap,
    input logic              ev_halt,
    input logic [ADDR_W-1:0] wptr,
    input logic [ADDR_W-1:0] cfg_base
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_req && !irq && !tr_ready && !drain_ack)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R3

    AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tr_ready |-> ((!mem_req || mem_gnt) && !drain_pend)); // R4

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |=> (wptr == cfg_base)); // R5

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> !tr_ready); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == 2'd3)) |=> irq); // R9

    AST_DRAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_ack |=> !drain_ack); // R11

    AST_DRAIN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        drain_ack |-> !mem_req); // R11

endmodule

bind trace_buf_writer trace_buf_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tr_ready(tr_ready), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .drain_ack(drain_ack),
    .drain_pend(drain_pend), .ev_wrap(ev_wrap), .ev_halt(ev_halt),
    .wptr(wptr), .cfg_base(cfg_base)
);

// File: tb/trace_buf_writer_test.sv
// Self-checking bench: a vector table for the streaming path, then
// directed tests for reset, back-pressure, drain, halts and collisions.
module trace_buf_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tr_valid = 1'b0;
    logic [7:0]  tr_data = '0;
    logic        tr_ready;
    logic        tr_trig = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_gnt = 1'b0;
    logic        drain_req = 1'b0;
    logic        drain_ack;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rv;

    // byte[39:32], expected address[31:0]; continuous mode crosses the limit at 0x2000
    localparam logic [39:0] VEC [8] = '{
        40'hA5_0000_1FFA, 40'h5A_0000_1FFB, 40'h3C_0000_1FFC, 40'hC3_0000_1FFD,
        40'h0F_0000_1FFE, 40'hF0_0000_1FFF, 40'h99_0000_1000, 40'h66_0000_1001
    };

    always #4 clk = ~clk;

    trace_buf_writer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_valid(tr_valid),
        .tr_data(tr_data), .tr_ready(tr_ready), .tr_trig(tr_trig),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_gnt(mem_gnt), .drain_req(drain_req), .drain_ack(drain_ack),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, tr_ready}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            chk("R1 reg", rv, 0);
        end
        @(negedge clk);

        // R2 page masking and field readback
        wr(2'd0, 32'h0000_1234);
        rd(2'd0, rv); chk("R2 base", rv, 32'h1000);
        wr(2'd2, 32'h0000_2FFA);
        rd(2'd2, rv); chk("R2 ctrl", rv, 32'h201A);
        wr(2'd1, 32'h0000_1FFA);
        rd(2'd1, rv); chk("R2 wptr", rv, 32'h1FFA);
        chk("R4 disabled not ready", {31'd0, tr_ready}, 0);

        // R6 continuous mode streaming through the vector table
        wr(2'd2, 32'h0000_2003);
        chk("R4 enabled ready", {31'd0, tr_ready}, 1);
        mem_gnt = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tr_valid = 1'b1; tr_data = VEC[i][39:32];
            @(negedge clk);
            chk("R3 addr", mem_addr, VEC[i][31:0]);
            chk("R3 data", {24'd0, mem_data}, {24'd0, VEC[i][39:32]});
        end
        tr_valid = 1'b0;
        @(negedge clk);
        rd(2'd3, rv); chk("R6 status", rv, 32'h005);
        chk("R6 still ready", {31'd0, tr_ready}, 1);
        chk("R9 irq high", {31'd0, irq}, 1);
        rd(2'd1, rv); chk("R6 wptr", rv, 32'h1002);
        wr(2'd3, 32'h0);
        chk("R9 irq cleared", {31'd0, irq}, 0);

        // R3 back-pressure
        mem_gnt = 1'b0;
        tr_valid = 1'b1; tr_data = 8'h11;
        @(negedge clk);
        chk("R3 req", {31'd0, mem_req}, 1);
        chk("R4 busy not ready", {31'd0, tr_ready}, 0);
        tr_data = 8'h22;
        @(negedge clk);
        chk("R3 held addr", mem_addr, 32'h1002);
        chk("R3 held data", {24'd0, mem_data}, 32'h11);
        mem_gnt = 1'b1;
        @(negedge clk);
        chk("R3 next addr", mem_addr, 32'h1003);
        chk("R3 next data", {24'd0, mem_data}, 32'h22);
        tr_valid = 1'b0;
        @(negedge clk);
        chk("R3 req released", {31'd0, mem_req}, 0);

        // R11 drain issued together with an accept
        mem_gnt = 1'b0;
        tr_valid = 1'b1; tr_data = 8'h33; drain_req = 1'b1;
        @(negedge clk);
        tr_valid = 1'b0; drain_req = 1'b0;
        chk("R11 ready low", {31'd0, tr_ready}, 0);
        chk("R11 no early ack", {31'd0, drain_ack}, 0);
        @(negedge clk);
        chk("R11 ack waits", {31'd0, drain_ack}, 0);
        mem_gnt = 1'b1;
        @(negedge clk);
        chk("R11 ack after grant", {31'd0, drain_ack}, 0);
        @(negedge clk);
        chk("R11 ack pulse", {31'd0, drain_ack}, 1);
        @(negedge clk);
        chk("R11 ack single", {31'd0, drain_ack}, 0);
        chk("R11 ready back", {31'd0, tr_ready}, 1);

        // R5 stop-on-wrap
        wr(2'd2, 32'h0000_2000);
        wr(2'd1, 32'h0000_1FFE);
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0000_2001);
        tr_valid = 1'b1; tr_data = 8'h44;
        @(negedge clk);
        tr_data = 8'h55;
        @(negedge clk);
        chk("R5 last addr", mem_addr, 32'h1FFF);
        @(negedge clk);
        tr_valid = 1'b0;
        chk("R5 halted", {31'd0, tr_ready}, 0);
        chk("R5 no extra write", {31'd0, mem_req}, 0);
        chk("R9 irq", {31'd0, irq}, 1);
        rd(2'd3, rv); chk("R5 status", rv, 32'h10D);
        rd(2'd1, rv); chk("R5 wptr at base", rv, 32'h1000);
        rd(2'd2, rv); chk("R8 ctrl kept", rv, 32'h2000);
        @(negedge clk);

        // R12 stop flag blocks re-enable
        wr(2'd2, 32'h0000_2001);
        chk("R12 still halted", {31'd0, tr_ready}, 0);
        rd(2'd2, rv); chk("R12 ctrl", rv, 32'h2001);
        @(negedge clk);

        // R10 software clear colliding with the wrap byte
        wr(2'd2, 32'h0000_2000);
        wr(2'd3, 32'h0);
        rd(2'd3, rv); chk("R10 sw clear", rv, 32'h0);
        @(negedge clk);
        wr(2'd1, 32'h0000_1FFF);
        wr(2'd2, 32'h0000_2001);
        tr_valid = 1'b1; tr_data = 8'h66;
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0; tr_valid = 1'b0;
        chk("R10 write landed", mem_addr, 32'h1FFF);
        rd(2'd3, rv); chk("R10 hw wins", rv, 32'h10D);
        @(negedge clk);

        // R7 trigger halt, then trigger ignored
        wr(2'd2, 32'h0000_2000);
        wr(2'd3, 32'h0);
        wr(2'd1, 32'h0000_1000);
        wr(2'd2, 32'h0000_2009);
        tr_trig = 1'b1;
        @(negedge clk);
        tr_trig = 1'b0;
        rd(2'd3, rv); chk("R7 trig status", rv, 32'h00B);
        chk("R7 halted", {31'd0, tr_ready}, 0);
        rd(2'd2, rv); chk("R8 ctrl after trig", rv, 32'h2008);
        @(negedge clk);
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0000_2001);
        tr_trig = 1'b1;
        @(negedge clk);
        tr_trig = 1'b0;
        rd(2'd3, rv); chk("R7 ignored status", rv, 32'h0);
        chk("R7 ignored ready", {31'd0, tr_ready}, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule